// File: doc/BRIEF.md
# Segmented DAC Switch-Control Front End

This block turns a 12-bit binary sample into the complete set of switch-control lines for a segmented current-steering converter. The top eight bits drive 255 equal-weight cells. The decode uses a two-dimensional scheme. The upper nibble of that field picks a row and the lower nibble picks a column, each through a 16-output thermometer decoder. A small gate at every cell then combines its row and column terms. The low four bits are not decoded. They pass through a register chain of the same length as the decoder pipeline, so they stay binary-weighted.

Every control line, unary and binary alike, is captured by one shared output register on the same clock edge. Each line is driven as a pair of complementary signals, one true and one inverted, for a differential switch. A new sample is accepted on every clock. Any sample appears at the outputs exactly two rising edges after it is captured.

Top module: `seg_dac_front`

## Requirements
- R1: Cell output `cell_p[i]`, for i from 0 to 254, is high exactly when the value of `code[11:4]` is greater than i, so the number of high cells equals that value.
- R2: Cells are arranged as 16 rows of 16, with cell index i = 16*row + col. The row field is `code[11:8]` and the column field is `code[7:4]`. A cell is on when its row is below the row field, or when its row equals the row field and its column is below the column field.
- R3: `lsb_p[3:0]` equals `code[3:0]` undecoded, with bit j carrying binary weight 2^j.
- R4: Unary and binary outputs come from the same sample. They change together two rising edges after the sample is captured, and a new sample is taken on every edge.
- R5: At all times `cell_n` is the bitwise inverse of `cell_p`, and `lsb_n` is the bitwise inverse of `lsb_p`.
- R6: An active-high synchronous reset makes every true output low and every inverted output high on the next rising edge.
- R7: Reset also clears the internal stage, so the first edge after reset is released still presents the zero code, whatever `code` held during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| code | input | 12 | Binary input sample |
| cell_p | output | 255 | Unary cell enables, true polarity |
| cell_n | output | 255 | Unary cell enables, inverted polarity |
| lsb_p | output | 4 | Binary-weighted low bits, true polarity |
| lsb_n | output | 4 | Binary-weighted low bits, inverted polarity |

## Verification
In every cycle the unary decode and the delayed binary path must land in the same output edge. A shift in either path would pair the upper bits of one sample with the lower bits of another. To provoke this, the bench drives every code back to back, first in order and then in a scrambled order. Each cycle it then compares the full unary vector and the low bits against one model sample, so a one-cycle skew between the paths breaks the comparison as soon as adjacent codes differ. The second overlap is a reset asserted while a nonzero sample is in flight. The outputs are checked for zero on the next edge and again on the first edge after release.

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
  parameter int MSB_W = 8,
  parameter int LSB_W = 4,
  parameter int ROW_W = MSB_W / 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MSB_W+LSB_W-1:0]   code,
  output logic [(1<<MSB_W)-2:0]    cell_p,
  output logic [(1<<MSB_W)-2:0]    cell_n,
  output logic [LSB_W-1:0]         lsb_p,
  output logic [LSB_W-1:0]         lsb_n
);
  localparam int COL_W = MSB_W - ROW_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;
  localparam int CELLS = (1 << MSB_W) - 1;
  localparam int W     = MSB_W + LSB_W;

  logic [ROW_W-1:0] row_f;
  logic [COL_W-1:0] col_f;
  logic [ROWS-1:0]  row_tn, row_t, row_at;
  logic [COLS-1:0]  col_tn, col_t;
  logic [LSB_W-1:0] lsb_d;
  logic [CELLS-1:0] cell_d;

  assign row_f = code[W-1 -: ROW_W];
  assign col_f = code[LSB_W +: COL_W];

  for (genvar k = 0; k < ROWS; k++) begin : g_rdec
    assign row_tn[k] = row_f > ROW_W'(k);
  end
  for (genvar k = 0; k < COLS; k++) begin : g_cdec
    assign col_tn[k] = col_f > COL_W'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_t <= '0;
      col_t <= '0;
      lsb_d <= '0;
    end else begin
      row_t <= row_tn;
      col_t <= col_tn;
      lsb_d <= code[LSB_W-1:0];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == 0) begin : g_first
      assign row_at[r] = ~row_t[r];
    end else begin : g_rest
      assign row_at[r] = ~row_t[r] & row_t[r-1];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_col
      if (r * COLS + c < CELLS) begin : g_cell
        assign cell_d[r*COLS+c] = row_t[r] | (row_at[r] & col_t[c]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_p <= '0;
      cell_n <= '1;
      lsb_p  <= '0;
      lsb_n  <= '1;
    end else begin
      cell_p <= cell_d;
      cell_n <= ~cell_d;
      lsb_p  <= lsb_d;
      lsb_n  <= ~lsb_d;
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R1
  unary_count_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> ($countones(cell_p) == int'($past(code[W-1:LSB_W], 2))));

  // R1
  unary_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (((cell_p + 1'b1) & cell_p) == '0));

  // R3
  lsb_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (lsb_p == $past(code[LSB_W-1:0], 2)));

  // R5
  pair_opposite_chk: assert property (@(posedge clk) disable iff (rst)
    (cell_n == ~cell_p) && (lsb_n == ~lsb_p));

  // R6
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (cell_p == '0 && lsb_p == '0 && cell_n == '1 && lsb_n == '1));
endmodule

// File: tb/tb_seg_dac_front.sv
`timescale 1ns/1ps
module tb_seg_dac_front;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  code = '0;
  logic [254:0] cell_p, cell_n;
  logic [3:0]   lsb_p, lsb_n;

  int checks = 0;
  int fails  = 0;
  int pipe   = 0;
  int expo   = 0;

  always #2.5 clk = ~clk;

  seg_dac_front dut (
    .clk(clk), .rst(rst), .code(code),
    .cell_p(cell_p), .cell_n(cell_n), .lsb_p(lsb_p), .lsb_n(lsb_n)
  );

  function automatic logic [254:0] unary_of(input int v);
    logic [254:0] u;
    for (int i = 0; i < 255; i++) u[i] = ((v >> 4) & 255) > i;
    return u;
  endfunction

  function automatic logic [254:0] rowcol_of(input int v);
    logic [254:0] u;
    int r0, c0;
    r0 = (v >> 8) & 15;
    c0 = (v >> 4) & 15;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        if (r * 16 + c < 255) u[r*16+c] = (r < r0) || (r == r0 && c < c0);
    return u;
  endfunction

  task automatic check_out(input int v, input string tag);
    logic [254:0] eu;
    eu = unary_of(v);
    checks++;
    if (cell_p !== eu) begin
      fails++;
      $display("FAIL R1 %s: cell_p=%h exp=%h", tag, cell_p, eu);
    end
    checks++;
    if (cell_p !== rowcol_of(v)) begin
      fails++;
      $display("FAIL R2 %s: cell_p=%h exp=%h", tag, cell_p, rowcol_of(v));
    end
    checks++;
    if (lsb_p !== 4'(v)) begin
      fails++;
      $display("FAIL R3/R4 %s: lsb_p=%h exp=%h", tag, lsb_p, 4'(v));
    end
    checks++;
    if (cell_n !== ~cell_p || lsb_n !== ~lsb_p) begin
      fails++;
      $display("FAIL R5 %s: cell_n=%h lsb_n=%h exp=%h %h", tag, cell_n, lsb_n, ~cell_p, ~lsb_p);
    end
  endtask

  task automatic step(input int v, input string tag);
    code = 12'(v);
    @(posedge clk);
    if (rst) begin
      expo = 0;
      pipe = 0;
    end else begin
      expo = pipe;
      pipe = v;
    end
    @(negedge clk);
    check_out(expo, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    code = 12'hFFF;
    // R6 reset state, R7 nonzero code held during reset
    for (int k = 0; k < 3; k++) step(12'hFFF, "R6 reset");
    rst = 1'b0;
    step(12'hABC, "R7 first after release");
    step(12'h123, "R4 pipeline fill");
    // R1 R2 R3 R4 ascending sweep
    for (int v = 0; v < 4096; v++) step(v, "ascending");
    // R4 scrambled order, adjacent codes differ
    for (int i = 0; i < 4096; i++) step((i * 1597 + 911) % 4096, "scrambled");
    // R6 reset with a full code in flight
    step(12'hFFF, "R6 load");
    step(12'hFF0, "R6 load");
    rst = 1'b1;
    step(12'hFFF, "R6 mid-stream");
    rst = 1'b0;
    step(12'hFFF, "R7 after mid reset");
    step(12'h00F, "R4 refill");
    step(12'h0F0, "R4 refill");
    step(0, "flush");
    step(0, "flush");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule